// File: doc/BRIEF.md
# Register Producer-Tag Rename Table

This block keeps one entry per architectural floating-point register. Each entry holds the register's committed value and a producer tag. The tag names the reservation station whose result the register is waiting for. Tag zero means no producer is pending, so the stored value is current.

During issue, the table answers two source lookups in the same cycle. For each source it returns either a ready value with tag zero, or the tag of the pending producer. On the clock edge it then writes the issuing station's tag into the destination entry. A destination that is still waiting on an older producer is simply retargeted to the new station, so name dependences never stall issue.

Completed results come in on a single broadcast bus. Every entry watches this bus and captures the data only when the broadcast tag equals its own recorded tag. When that happens the entry also clears its tag back to zero.

Top module: `rrs_rename_table`

## Requirements
- R1: After reset every entry has tag 0 and value 0.
- R2: A lookup of a register whose tag is 0 returns the stored value with tag 0.
- R3: A lookup of a register whose tag is nonzero returns that tag on the tag output.
- R4: An issue (valid high, nonzero tag) records the issuing tag in the destination entry, and it is visible from the next cycle.
- R5: Issuing to a register that already has a pending producer replaces the old tag with the new one.
- R6: A valid broadcast whose nonzero tag equals an entry's tag writes the broadcast data into that entry and clears its tag to 0 on the next edge.
- R7: A broadcast whose tag differs from an entry's tag changes neither the entry's value nor its tag, so a superseded producer never updates the register.
- R8: When an issue and a matching broadcast hit the same register in one cycle, the entry ends with the new issue tag.
- R9: A lookup made in the same cycle as a matching broadcast returns the broadcast data with tag 0.
- R10: A broadcast with the valid input low, or with tag 0, has no effect on any entry.
- R11: Source lookups always see the table state from before the current cycle's issue, even when the destination is also a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iss_valid_i | input | 1 | Issue update strobe |
| iss_tag_i | input | TAG_W | Tag of the issuing station (nonzero) |
| iss_dst_i | input | IDX_W | Destination register index |
| src_a_idx_i | input | IDX_W | Source A register index |
| src_b_idx_i | input | IDX_W | Source B register index |
| src_a_val_o | output | DATA_W | Source A value |
| src_a_tag_o | output | TAG_W | Source A producer tag, 0 when ready |
| src_b_val_o | output | DATA_W | Source B value |
| src_b_tag_o | output | TAG_W | Source B producer tag, 0 when ready |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TAG_W | Tag of the broadcasting station |
| bc_data_i | input | DATA_W | Broadcast result |

## Verification
A corrupted tag shows up at the lookup outputs in the very next cycle. If an entry's tag is wrong, a lookup reports the wrong producer. It also lets a later broadcast be dropped or taken by the wrong register. That second error becomes visible on the first lookup after the broadcast. A faulty compare or priority path changes the value or tag of one register only, so it surfaces on the first lookup of that register. The directed scenarios therefore read each touched register back one cycle after every update. They also read it during same-cycle bus activity.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int unsigned DEF_NUM_REGS = 16;
  localparam int unsigned DEF_DATA_W   = 64;
  localparam int unsigned DEF_TAG_W    = 4;
  localparam int unsigned NUM_SRC      = 2;
endpackage

// File: rtl/rrs_entry.sv
module rrs_entry #(
  parameter int unsigned DATA_W = rrs_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W  = rrs_pkg::DEF_TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_sel_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] val_o
);
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;
  logic              hit;

  assign hit = bc_valid_i && (bc_tag_i != '0) && (tag_q == bc_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      val_q <= '0;
    end else begin
      if (hit) val_q <= bc_data_i;
      // new issue outranks a clearing broadcast
      if (wr_sel_i)  tag_q <= wr_tag_i;
      else if (hit)  tag_q <= '0;
    end
  end

  assign tag_o = tag_q;
  assign val_o = val_q;
endmodule

// File: rtl/rrs_read_port.sv
module rrs_read_port #(
  parameter int unsigned NUM_REGS = rrs_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rrs_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W    = rrs_pkg::DEF_TAG_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] val_vec_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic                            bc_valid_i,
  input  logic [TAG_W-1:0]                bc_tag_i,
  input  logic [DATA_W-1:0]               bc_data_i,
  output logic [DATA_W-1:0]               val_o,
  output logic [TAG_W-1:0]                tag_o
);
  logic [TAG_W-1:0] sel_tag;

  always_comb begin
    sel_tag = tag_vec_i[idx_i];
    if (sel_tag != '0 && bc_valid_i && sel_tag == bc_tag_i) begin
      val_o = bc_data_i;
      tag_o = '0;
    end else begin
      val_o = val_vec_i[idx_i];
      tag_o = sel_tag;
    end
  end
endmodule

// File: rtl/rrs_rename_table.sv
module rrs_rename_table #(
  parameter int unsigned NUM_REGS = rrs_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rrs_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W    = rrs_pkg::DEF_TAG_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [TAG_W-1:0]  iss_tag_i,
  input  logic [IDX_W-1:0]  iss_dst_i,
  input  logic [IDX_W-1:0]  src_a_idx_i,
  input  logic [IDX_W-1:0]  src_b_idx_i,
  output logic [DATA_W-1:0] src_a_val_o,
  output logic [TAG_W-1:0]  src_a_tag_o,
  output logic [DATA_W-1:0] src_b_val_o,
  output logic [TAG_W-1:0]  src_b_tag_o,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i
);
  localparam int unsigned NSRC = rrs_pkg::NUM_SRC;

  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] val_vec;
  logic [NSRC-1:0][IDX_W-1:0]      src_idx;
  logic [NSRC-1:0][DATA_W-1:0]     src_val;
  logic [NSRC-1:0][TAG_W-1:0]      src_tag;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
    logic sel;
    assign sel = iss_valid_i && (iss_dst_i == IDX_W'(r));
    rrs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_ent (
      .clk_i, .rst_ni,
      .wr_sel_i  (sel),
      .wr_tag_i  (iss_tag_i),
      .bc_valid_i, .bc_tag_i, .bc_data_i,
      .tag_o     (tag_vec[r]),
      .val_o     (val_vec[r])
    );
  end

  assign src_idx[0] = src_a_idx_i;
  assign src_idx[1] = src_b_idx_i;

  for (genvar s = 0; s < NSRC; s++) begin : g_rd
    rrs_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_rd (
      .tag_vec_i (tag_vec),
      .val_vec_i (val_vec),
      .idx_i     (src_idx[s]),
      .bc_valid_i, .bc_tag_i, .bc_data_i,
      .val_o     (src_val[s]),
      .tag_o     (src_tag[s])
    );
  end

  assign src_a_val_o = src_val[0];
  assign src_a_tag_o = src_tag[0];
  assign src_b_val_o = src_val[1];
  assign src_b_tag_o = src_tag[1];
endmodule

// File: rtl/rrs_rename_table_chk.sv
module rrs_rename_table_chk #(
  parameter int unsigned NUM_REGS = rrs_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rrs_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W    = rrs_pkg::DEF_TAG_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            iss_valid_i,
  input logic [TAG_W-1:0]                iss_tag_i,
  input logic [IDX_W-1:0]                iss_dst_i,
  input logic [IDX_W-1:0]                src_a_idx_i,
  input logic [DATA_W-1:0]               src_a_val_o,
  input logic [TAG_W-1:0]                src_a_tag_o,
  input logic                            bc_valid_i,
  input logic [TAG_W-1:0]                bc_tag_i,
  input logic [DATA_W-1:0]               bc_data_i,
  input logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec,
  input logic [NUM_REGS-1:0][DATA_W-1:0] val_vec
);
  logic bc_live;
  assign bc_live = bc_valid_i && (bc_tag_i != '0);

  AST_ISSUE_RECORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_i |=> tag_vec[$past(iss_dst_i)] == $past(iss_tag_i)); // R4

  AST_FWD_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_live && tag_vec[src_a_idx_i] == bc_tag_i) |-> (src_a_tag_o == '0 && src_a_val_o == bc_data_i)); // R9

  AST_READY_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_vec[src_a_idx_i] == '0) |-> (src_a_tag_o == '0 && src_a_val_o == val_vec[src_a_idx_i])); // R2

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic tgt;
    assign tgt = iss_valid_i && (iss_dst_i == IDX_W'(r));

    AST_HIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bc_live && tag_vec[r] == bc_tag_i && !tgt) |=> (tag_vec[r] == '0 && val_vec[r] == $past(bc_data_i))); // R6

    AST_STALE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(bc_live && tag_vec[r] == bc_tag_i) && !tgt) |=> ($stable(tag_vec[r]) && $stable(val_vec[r]))); // R7

    AST_ISSUE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bc_live && tag_vec[r] == bc_tag_i && tgt) |=> tag_vec[r] == $past(iss_tag_i)); // R8
  end
endmodule

bind rrs_rename_table rrs_rename_table_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .iss_valid_i(iss_valid_i), .iss_tag_i(iss_tag_i), .iss_dst_i(iss_dst_i),
  .src_a_idx_i(src_a_idx_i), .src_a_val_o(src_a_val_o), .src_a_tag_o(src_a_tag_o),
  .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
  .tag_vec(tag_vec), .val_vec(val_vec)
);

// File: tb/test_rrs_rename_table.sv
module test_rrs_rename_table;
  localparam int unsigned NR = 16;
  localparam int unsigned DW = 64;
  localparam int unsigned TW = 4;
  localparam int unsigned IW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic [TW-1:0] iss_tag = '0;
  logic [IW-1:0] iss_dst = '0;
  logic [IW-1:0] src_a = '0, src_b = '0;
  logic [DW-1:0] a_val, b_val;
  logic [TW-1:0] a_tag, b_tag;
  logic          bc_valid = 1'b0;
  logic [TW-1:0] bc_tag = '0;
  logic [DW-1:0] bc_data = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rrs_rename_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW)) i_rrs_rename_table (
    .clk_i(clk), .rst_ni(rst_n),
    .iss_valid_i(iss_valid), .iss_tag_i(iss_tag), .iss_dst_i(iss_dst),
    .src_a_idx_i(src_a), .src_b_idx_i(src_b),
    .src_a_val_o(a_val), .src_a_tag_o(a_tag),
    .src_b_val_o(b_val), .src_b_tag_o(b_tag),
    .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_data_i(bc_data)
  );

  task automatic chk(string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // look up register on port A then port B, after a settle delay
  task automatic look(input logic [IW-1:0] r, input logic [TW-1:0] et,
                      input logic [DW-1:0] ev, input bit chk_val, input string rq);
    src_a = r; src_b = r;
    #1;
    chk(rq, "tag A", DW'(a_tag), DW'(et));
    chk(rq, "tag B", DW'(b_tag), DW'(et));
    if (chk_val) chk(rq, "value A", a_val, ev);
  endtask

  // drive one cycle of activity from a negedge, return at the next negedge idle
  task automatic step(input bit iv, input logic [IW-1:0] d, input logic [TW-1:0] t,
                      input bit bv, input logic [TW-1:0] bt, input logic [DW-1:0] bd);
    iss_valid = iv; iss_dst = d; iss_tag = t;
    bc_valid = bv; bc_tag = bt; bc_data = bd;
    @(negedge clk);
    iss_valid = 1'b0; bc_valid = 1'b0; bc_tag = '0;
  endtask

  task automatic t_reset;
    look(4'd0, '0, '0, 1'b1, "R1");
    look(4'd9, '0, '0, 1'b1, "R1");
    look(4'd15, '0, '0, 1'b1, "R1");
  endtask

  task automatic t_issue_and_result;
    step(1, 4'd3, 4'd5, 0, '0, '0);
    look(4'd3, 4'd5, '0, 1'b0, "R3 R4");
    step(0, '0, '0, 1, 4'd5, 64'hAAAA_0000_1111_2222);
    look(4'd3, '0, 64'hAAAA_0000_1111_2222, 1'b1, "R6 R2");
  endtask

  task automatic t_waw;
    step(1, 4'd4, 4'd6, 0, '0, '0);
    step(1, 4'd4, 4'd7, 0, '0, '0);
    look(4'd4, 4'd7, '0, 1'b0, "R5");
    step(0, '0, '0, 1, 4'd6, 64'hDEAD_DEAD_DEAD_DEAD);
    look(4'd4, 4'd7, '0, 1'b0, "R7");
    step(0, '0, '0, 1, 4'd7, 64'h0123_4567_89AB_CDEF);
    look(4'd4, '0, 64'h0123_4567_89AB_CDEF, 1'b1, "R6");
  endtask

  task automatic t_same_cycle;
    step(1, 4'd5, 4'd8, 0, '0, '0);
    step(1, 4'd5, 4'd9, 1, 4'd8, 64'h5555);
    look(4'd5, 4'd9, '0, 1'b0, "R8");
    step(0, '0, '0, 1, 4'd9, 64'h9999);
    look(4'd5, '0, 64'h9999, 1'b1, "R8");
  endtask

  task automatic t_forward;
    step(1, 4'd6, 4'd10, 0, '0, '0);
    src_a = 4'd6; src_b = 4'd6;
    bc_valid = 1'b1; bc_tag = 4'd10; bc_data = 64'hF00D_CAFE;
    #1;
    chk("R9", "fwd tag", DW'(a_tag), '0);
    chk("R9", "fwd value", a_val, 64'hF00D_CAFE);
    @(negedge clk);
    bc_valid = 1'b0; bc_tag = '0;
    look(4'd6, '0, 64'hF00D_CAFE, 1'b1, "R9");
  endtask

  task automatic t_ignored_bus;
    step(1, 4'd7, 4'd11, 0, '0, '0);
    step(0, '0, '0, 0, 4'd11, 64'h1);
    look(4'd7, 4'd11, '0, 1'b0, "R10");
    step(0, '0, '0, 1, 4'd0, 64'h2);
    look(4'd7, 4'd11, '0, 1'b0, "R10");
    look(4'd0, '0, '0, 1'b1, "R10");
  endtask

  task automatic t_self_source;
    src_a = 4'd3; src_b = 4'd4;
    iss_valid = 1'b1; iss_dst = 4'd3; iss_tag = 4'd12;
    #1;
    chk("R11", "old tag", DW'(a_tag), '0);
    chk("R11", "old value", a_val, 64'hAAAA_0000_1111_2222);
    @(negedge clk);
    iss_valid = 1'b0;
    look(4'd3, 4'd12, '0, 1'b0, "R11");
  endtask

  initial begin
    fork
      begin
        #5 look(4'd2, '0, '0, 1'b1, "R1");
        #30 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_issue_and_result();
        t_waw();
        t_same_cycle();
        t_forward();
        t_ignored_bus();
        t_self_source();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule